// File: doc/BRIEF.md
# Periodic interrupt generator

This block turns a 32.768 kHz time-base enable input into a periodic event with a programmable rate. A host programs two byte-wide control registers through a simple synchronous register port. The first holds a 4-bit rate code and a 3-bit divider mode. The second holds an interrupt enable and a square-wave enable. Each completed period sets an event flag. The flag stays set until the host reads the status register. The interrupt request is the flag gated by the enable. A square wave at the selected rate can be driven from the same divider.

The rate code is not a plain exponent. Code 0 turns the output off. Codes 1 and 2 give 256 Hz and 128 Hz. Codes 3 to 15 give 32768 / 2^(code-1) Hz. Counted in base ticks, the period is 128 ticks for code 1, 256 ticks for code 2, and 2^(code-1) ticks for codes 3 to 15. Any write to control register A restarts the divider phase.

Top module: `rate_irq_gen`

## Requirements
- R1: After reset all of the following are 0: both control registers, the event flag, `irq`, `sqw` and `host_rdata`.
- R2: Address 0 is control A: bits 6..4 hold the divider mode, bits 3..0 the rate code, and bit 7 reads 0. Address 1 is control B and keeps only bit 6 (interrupt enable) and bit 3 (square-wave enable); its other bits read 0. Address 2 is status, with the event flag at bit 6. Address 3 reads 0. Writes to addresses 2 and 3 are ignored. Read data appears on `host_rdata` one clock after the cycle with `host_rd` high, and holds until the next read.
- R3: The divider runs only when the divider mode is 3'b010 and the rate code is non-zero. Otherwise the divider is held at its start and no event occurs.
- R4: For rate codes 3 to 15, the period is 2^(code-1) base ticks. One base tick is a clock cycle with `base_tick` high.
- R5: Rate code 1 gives a period of 128 base ticks. Rate code 2 gives a period of 256 base ticks.
- R6: The event flag is set at the clock edge that samples the last base tick of a period. It then stays set until it is cleared by a status read.
- R7: A status read returns the flag at bit 6 and clears the flag at the same edge. If an event falls on the same edge as the read, the flag stays set.
- R8: `irq` is high exactly when the event flag is set and control B bit 6 is 1. It falls in the cycle after a clearing read.
- R9: When control B bit 3 is 1 and the divider runs, `sqw` is low for the first half of each period and high for the second half. Otherwise `sqw` is 0.
- R10: Any write to control A restarts the divider. A base tick in the write cycle is not counted, and the next event comes one full period of the new code after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | One-cycle enable at the 32.768 kHz time-base rate |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, registered |
| evt_flag | output | 1 | Periodic event flag |
| irq | output | 1 | Interrupt request |
| sqw | output | 1 | Square wave at the selected rate |

## Verification
Read data, the event flag and the register contents all change at the edge that samples a strobe or a tick. The flag is set at the edge that counts the last tick of a period, and `irq` and `sqw` follow the registers with no further delay. The bench therefore drives inputs and samples outputs on the falling edge. Its behavioural model steps once per rising edge, so every output is compared exactly one edge after the stimulus that caused it. Period checks start counting at the falling edge just after a restarting write and stop when the flag is first seen. The expected count is therefore the period in ticks when a tick arrives every cycle.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int RATE_W  = 4;
    localparam int MODE_W  = 3;
    localparam int EXP_W   = 4;
    localparam int CNT_W   = 15;

    localparam logic [ADDR_W-1:0] ADR_CTLA = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_CTLB = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_STAT = 2'd2;

    localparam logic [MODE_W-1:0] MODE_RUN = 3'b010;

    localparam int BIT_IEN  = 6;
    localparam int BIT_SQEN = 3;
    localparam int BIT_FLAG = 6;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [RATE_W-1:0] rate;
    } ctla_t;

    typedef struct packed {
        logic ien;
        logic sqen;
    } ctlb_t;

endpackage

// File: rtl/pirq_rate_decode.sv
module pirq_rate_decode
    import pirq_pkg::*;
#(
    parameter int RW = RATE_W,
    parameter int EW = EXP_W
) (
    input  logic [RW-1:0] rate,
    output logic          valid,
    output logic [EW-1:0] exp_log2
);
    // Period in base ticks is 2**exp_log2.
    localparam logic [EW-1:0] EXP_CODE1 = EW'(7);
    localparam logic [EW-1:0] EXP_CODE2 = EW'(8);

    always_comb begin
        valid = (rate != '0);
        if (rate == RW'(1)) begin
            exp_log2 = EXP_CODE1;
        end else if (rate == RW'(2)) begin
            exp_log2 = EXP_CODE2;
        end else if (rate == '0) begin
            exp_log2 = '0;
        end else begin
            exp_log2 = EW'(rate - RW'(1));
        end
    end
endmodule

// File: rtl/pirq_divider.sv
module pirq_divider
    import pirq_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int EW = EXP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic          tick,
    input  logic [EW-1:0] exp_log2,
    output logic          evt,
    output logic          tap,
    output logic [CW-1:0] cnt
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [CW-1:0] last_mask;
    logic [CW-1:0] tap_sel;

    // last_mask has the low exp_log2 bits set; tap_sel picks bit exp_log2-1.
    for (genvar g = 0; g < CW; g++) begin : g_mask
        assign last_mask[g] = (32'(g) < 32'(exp_log2));
        assign tap_sel[g]   = (32'(g) + 32'd1 == 32'(exp_log2));
    end

    always_comb begin
        evt  = run && tick && !restart && (st_q.cnt == last_mask);
        st_d = st_q;
        if (restart || !run) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = evt ? '0 : st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tap = |(st_q.cnt & tap_sel);
    assign cnt = st_q.cnt;
endmodule

// File: rtl/pirq_host_regs.sv
module pirq_host_regs
    import pirq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          evt,
    output ctla_t         ctla,
    output ctlb_t         ctlb,
    output logic          flag,
    output logic          restart,
    output logic [DW-1:0] rdata
);
    typedef struct packed {
        ctla_t         ctla;
        ctlb_t         ctlb;
        logic          flag;
        logic [DW-1:0] rdata;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic [DW-1:0] rd_mux;
    logic stat_rd;
    logic unused_wbits;

    assign unused_wbits = ^{wdata[DW-1], wdata[5:4], wdata[2:0]};
    assign stat_rd = rd_en && (addr == ADR_STAT);
    assign restart = wr_en && (addr == ADR_CTLA);

    always_comb begin
        rd_mux = '0;
        case (addr)
            ADR_CTLA: rd_mux[MODE_W+RATE_W-1:0] = st_q.ctla;
            ADR_CTLB: begin
                rd_mux[BIT_IEN]  = st_q.ctlb.ien;
                rd_mux[BIT_SQEN] = st_q.ctlb.sqen;
            end
            ADR_STAT: rd_mux[BIT_FLAG] = st_q.flag;
            default:  rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.ctla = ctla_t'(wdata[MODE_W+RATE_W-1:0]);
        end
        if (wr_en && (addr == ADR_CTLB)) begin
            st_d.ctlb.ien  = wdata[BIT_IEN];
            st_d.ctlb.sqen = wdata[BIT_SQEN];
        end
        if (rd_en) begin
            st_d.rdata = rd_mux;
        end
        if (evt) begin
            st_d.flag = 1'b1;
        end else if (stat_rd) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctla  = st_q.ctla;
    assign ctlb  = st_q.ctlb;
    assign flag  = st_q.flag;
    assign rdata = st_q.rdata;
endmodule

// File: rtl/rate_irq_gen.sv
module rate_irq_gen
    import pirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              evt_flag,
    output logic              irq,
    output logic              sqw
);
    ctla_t            ctla;
    ctlb_t            ctlb;
    logic             restart;
    logic             rate_ok;
    logic [EXP_W-1:0] exp_log2;
    logic             run;
    logic             evt_pulse;
    logic             tap;
    logic [CNT_W-1:0] cnt;
    logic             ien;
    logic             sqen;

    pirq_host_regs #(.AW(ADDR_W), .DW(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_wr),
        .rd_en   (host_rd),
        .addr    (host_addr),
        .wdata   (host_wdata),
        .evt     (evt_pulse),
        .ctla    (ctla),
        .ctlb    (ctlb),
        .flag    (evt_flag),
        .restart (restart),
        .rdata   (host_rdata)
    );

    pirq_rate_decode #(.RW(RATE_W), .EW(EXP_W)) u_dec (
        .rate     (ctla.rate),
        .valid    (rate_ok),
        .exp_log2 (exp_log2)
    );

    assign run  = rate_ok && (ctla.mode == MODE_RUN);
    assign ien  = ctlb.ien;
    assign sqen = ctlb.sqen;

    pirq_divider #(.CW(CNT_W), .EW(EXP_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .restart  (restart),
        .tick     (base_tick),
        .exp_log2 (exp_log2),
        .evt      (evt_pulse),
        .tap      (tap),
        .cnt      (cnt)
    );

    assign irq = evt_flag && ien;
    assign sqw = sqen && run && tap;
endmodule

module rate_irq_gen_chk
    import pirq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_rd,
    input logic [ADDR_W-1:0] host_addr,
    input logic              evt_flag,
    input logic              irq,
    input logic              sqw,
    input logic              run,
    input logic              evt_pulse,
    input logic [CNT_W-1:0]  cnt
);
    assert_stopped_no_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !$rose(evt_flag));

    assert_flag_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flag && !(host_rd && host_addr == ADR_STAT)) |=> evt_flag);

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == ADR_STAT && !evt_pulse) |=> !evt_flag);

    assert_irq_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == ADR_STAT && !evt_pulse) |=> !irq);

    assert_sqw_low_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !sqw);

    assert_restart_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == ADR_CTLA) |=> (cnt == '0));
endmodule

bind rate_irq_gen rate_irq_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_addr (host_addr),
    .evt_flag  (evt_flag),
    .irq       (irq),
    .sqw       (sqw),
    .run       (run),
    .evt_pulse (evt_pulse),
    .cnt       (cnt)
);

// File: tb/rate_irq_gen_bench.sv
module rate_irq_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       evt_flag;
    logic       irq;
    logic       sqw;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tick_mode = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rate_irq_gen u_rate_irq_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_tick  (base_tick),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .evt_flag   (evt_flag),
        .irq        (irq),
        .sqw        (sqw)
    );

    // ---------------- reference model ----------------
    logic [7:0] m_a, m_b, m_rd;
    bit         m_flag;
    int         m_cnt;

    function automatic int rate_hz(input int code);
        if (code == 1) return 256;
        if (code == 2) return 128;
        return 32768 >> (code - 1);
    endfunction

    function automatic bit m_run();
        return (m_a[6:4] == 3'b010) && (m_a[3:0] != 4'd0);
    endfunction

    function automatic int m_period();
        return 32768 / rate_hz(int'(m_a[3:0]));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_a = 8'd0; m_b = 8'd0; m_rd = 8'd0; m_flag = 0; m_cnt = 0;
        end else begin
            bit ev;
            logic [7:0] rd_val;
            ev = 0;
            rd_val = 8'd0;
            case (host_addr)
                2'd0: rd_val = m_a & 8'h7F;
                2'd1: rd_val = m_b & 8'h48;
                2'd2: rd_val = m_flag ? 8'h40 : 8'h00;
                default: rd_val = 8'h00;
            endcase
            if (host_wr && host_addr == 2'd0) m_cnt = 0;
            else if (!m_run()) m_cnt = 0;
            else if (base_tick) begin
                if (m_cnt == m_period() - 1) begin ev = 1; m_cnt = 0; end
                else m_cnt = m_cnt + 1;
            end
            if (host_rd) m_rd = rd_val;
            if (ev) m_flag = 1;
            else if (host_rd && host_addr == 2'd2) m_flag = 0;
            if (host_wr && host_addr == 2'd0) m_a = host_wdata & 8'h7F;
            if (host_wr && host_addr == 2'd1) m_b = host_wdata & 8'h48;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R6 flag", int'(evt_flag), int'(m_flag));
            check("R8 irq", int'(irq), int'(m_flag && m_b[6]));
            check("R9 sqw", int'(sqw),
                  int'(m_b[3] && m_run() && (m_cnt >= m_period() / 2)));
            check("R2 rdata", int'(host_rdata), int'(m_rd));
        end
    end

    // time-base tick pattern
    always @(negedge clk) begin
        case (tick_mode)
            1: base_tick = 1'b1;
            2: base_tick = (cyc % 3 == 0);
            default: base_tick = 1'b0;
        endcase
    end

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    // ---------------- host tasks ----------------
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic measure(input string req, input logic [3:0] code, input int exp_cycles);
        logic [7:0] d;
        int n;
        wr(2'd0, 8'h00);
        rd(2'd2, d);
        wr(2'd0, {1'b0, 3'b010, code});
        n = 0;
        while (!evt_flag && n < 40000) begin
            @(negedge clk);
            n++;
        end
        check(req, n, exp_cycles);
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 flag", int'(evt_flag), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 sqw", int'(sqw), 0);
        check("R1 rdata", int'(host_rdata), 0);
        rd(2'd0, d); check("R1 ctla", int'(d), 0);
        rd(2'd1, d); check("R1 ctlb", int'(d), 0);

        // R2: register map, masks, ignored writes
        wr(2'd1, 8'hFF);
        rd(2'd1, d); check("R2 ctlb mask", int'(d), 8'h48);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hFF);
        rd(2'd0, d); check("R2 ctla mask", int'(d), 8'h7F);
        rd(2'd2, d);
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'hFF);
        rd(2'd2, d); check("R2 status write ignored", int'(d), 0);
        rd(2'd3, d); check("R2 addr3 reads zero", int'(d), 0);

        tick_mode = 1;
        // R4 / R5: periods, one tick per cycle
        measure("R4 code3 period", 4'd3, 4);
        measure("R4 code7 period", 4'd7, 64);
        measure("R5 code1 period", 4'd1, 128);
        measure("R5 code2 period", 4'd2, 256);
        measure("R4 code15 period", 4'd15, 16384);

        // R6 / R8: flag holds with divider stopped; irq gating
        measure("R4 code3 again", 4'd3, 4);
        wr(2'd0, 8'h03);
        repeat (10) @(negedge clk);
        check("R6 flag held", int'(evt_flag), 1);
        check("R8 irq masked", int'(irq), 0);
        wr(2'd1, 8'h40);
        check("R8 irq enabled", int'(irq), 1);
        rd(2'd2, d);
        check("R7 status value", int'(d), 8'h40);
        check("R7 flag cleared", int'(evt_flag), 0);
        check("R8 irq dropped", int'(irq), 0);

        // R3: stopped by mode or by rate code 0
        wr(2'd0, 8'h35);
        repeat (200) @(negedge clk);
        check("R3 mode off no event", int'(evt_flag), 0);
        wr(2'd0, 8'h20);
        repeat (200) @(negedge clk);
        check("R3 rate0 no event", int'(evt_flag), 0);
        check("R3 rate0 no sqw", int'(sqw), 0);

        // R10: restart on rewrite of control A
        wr(2'd0, 8'h00);
        rd(2'd2, d);
        wr(2'd0, 8'h26);
        repeat (20) @(negedge clk);
        check("R10 no early event", int'(evt_flag), 0);
        measure("R10 restart full period", 4'd6, 32);

        // R9: square wave, compared cycle by cycle
        wr(2'd1, 8'h48);
        wr(2'd0, 8'h24);
        repeat (40) @(negedge clk);

        // R7: continuous status reads to hit read/event coincidence
        wr(2'd0, 8'h23);
        for (int i = 0; i < 24; i++) rd(2'd2, d);

        // sparse ticks, every third cycle
        tick_mode = 2;
        wr(2'd0, 8'h24);
        repeat (300) @(negedge clk);
        for (int i = 0; i < 10; i++) rd(2'd2, d);
        tick_mode = 0;
        repeat (5) @(negedge clk);

        finish_run();
    end
endmodule